// File: doc/BRIEF.md
# Packed Relative Branch Unit

This block resolves the two-byte relative control-transfer instructions of a small 8-bit processor that has a 16-bit program counter. Each instruction carries a 12-bit signed displacement. Its top four bits sit in the low nibble of the first byte, and the low eight bits form the second byte. The upper nibble of the first byte chooses among seven operations:

- an unconditional jump
- a relative call
- four flag-conditional jumps
- a jump that also adds the accumulator into the destination

The block computes all of the following:

- whether control is transferred
- the next program counter
- a push request and return address for calls
- the cycle cost of the instruction

The fetch stage presents both instruction bytes, the address of the first byte, the accumulator and the carry and zero flags, and raises `in_valid`. One clock later the registered result appears, qualified by `out_valid`. The block never writes the accumulator or the flags.

Top module: `rel_branch_unit`

## Requirements
- R1: After reset, and on every cycle where `out_valid` is low, `taken` and `push_ret` are low.
- R2: `out_valid` rises exactly one cycle after an `in_valid` cycle whose first byte has an upper nibble from 0x8 to 0xE. An upper nibble outside that range, or `in_valid` low, gives `out_valid` low on the next cycle.
- R3: The displacement is {first byte bits 3:0, second byte}, read as a 12-bit two's-complement value and sign-extended to 16 bits.
- R4: For upper nibble 0x8 (unconditional jump) and 0x9 (call), `taken` is high and `target` is the first-byte address + 1 + displacement.
- R5: For upper nibble 0xE, `taken` is high and `target` is the first-byte address + 1 + displacement + accumulator. The accumulator is treated as unsigned, and the carry and zero flags have no effect.
- R6: Nibble 0xA jumps when the zero flag is 1, 0xB when it is 0, 0xC when the carry flag is 1, and 0xD when it is 0. A taken conditional uses the R4 target. A conditional that is not taken gives `taken` low and `target` = first-byte address + 2.
- R7: `push_ret` is high only for nibble 0x9, and then `ret_addr` equals the first-byte address + 2.
- R8: `cycles` reports 5 for the unconditional and conditional jumps (taken or not), 7 for the accumulator jump and 11 for the call.
- R9: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bytes and state are presented |
| byte0 | input | 8 | First instruction byte (operation nibble, displacement high nibble) |
| byte1 | input | 8 | Second instruction byte (displacement low byte) |
| pc | input | 16 | Address of the first instruction byte |
| acc | input | 8 | Accumulator value |
| cf | input | 1 | Carry flag |
| zf | input | 1 | Zero flag |
| out_valid | output | 1 | Result registered and recognized |
| taken | output | 1 | Control transfer happens |
| target | output | 16 | Next program counter |
| push_ret | output | 1 | Call wants its return address pushed |
| ret_addr | output | 16 | Return address for a call |
| cycles | output | 4 | Cycle cost of the instruction |

## Verification
Every result (`out_valid`, `taken`, `target`, `push_ret`, `ret_addr` and `cycles`) is due on the first rising edge after the edge that captures the inputs. The bench drives each stimulus on a falling edge and samples on the next falling edge, half a period after the result register loads. It never samples a result in the same cycle as its stimulus, and it never samples one a cycle late.

// File: rtl/rel_branch_unit.sv
module rel_branch_unit #(
  parameter int PC_W     = 16,
  parameter int OFF_W    = 12,
  parameter int DATA_W   = 8,
  parameter int CYC_W    = 4,
  parameter int CYC_JMP  = 5,
  parameter int CYC_ACC  = 7,
  parameter int CYC_CALL = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] byte0,
  input  logic [DATA_W-1:0] byte1,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] acc,
  input  logic              cf,
  input  logic              zf,
  output logic              out_valid,
  output logic              taken,
  output logic [PC_W-1:0]   target,
  output logic              push_ret,
  output logic [PC_W-1:0]   ret_addr,
  output logic [CYC_W-1:0]  cycles
);
  localparam int NIB_W = OFF_W - DATA_W;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);
  localparam logic [PC_W-1:0] TWO = PC_W'(2);

  logic [3:0]       grp;
  logic [OFF_W-1:0] disp;
  logic [PC_W-1:0]  disp_ext, acc_ext, rel_dst, seq_pc;
  logic             recog, go, is_call, is_acc;

  assign grp      = byte0[DATA_W-1 -: 4];
  assign disp     = {byte0[NIB_W-1:0], byte1};
  assign disp_ext = {{(PC_W-OFF_W){disp[OFF_W-1]}}, disp};
  assign acc_ext  = is_acc ? {{(PC_W-DATA_W){1'b0}}, acc} : '0;
  assign rel_dst  = pc + ONE + disp_ext + acc_ext;
  assign seq_pc   = pc + TWO;

  always_comb begin
    recog   = 1'b1;
    go      = 1'b0;
    is_call = 1'b0;
    is_acc  = 1'b0;
    unique case (grp)
      4'h8: go = 1'b1;
      4'h9: begin go = 1'b1; is_call = 1'b1; end
      4'hA: go = zf;
      4'hB: go = !zf;
      4'hC: go = cf;
      4'hD: go = !cf;
      4'hE: begin go = 1'b1; is_acc = 1'b1; end
      default: recog = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      push_ret  <= 1'b0;
      target    <= '0;
      ret_addr  <= '0;
      cycles    <= '0;
    end else begin
      out_valid <= in_valid && recog;
      taken     <= in_valid && recog && go;
      push_ret  <= in_valid && is_call;
      target    <= go ? rel_dst : seq_pc;
      ret_addr  <= seq_pc;
      cycles    <= is_call ? CYC_W'(CYC_CALL) : is_acc ? CYC_W'(CYC_ACC) : CYC_W'(CYC_JMP);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!taken && !push_ret));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte0[7:4] >= 4'h8 && byte0[7:4] <= 4'hE) |=> out_valid);
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !byte0[7] || byte0[7:4] == 4'hF) |=> !out_valid);
  p_uncond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte0[7:4] == 4'h8) |=> taken);
  p_fallthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (target == $past(pc) + TWO && cycles == CYC_W'(CYC_JMP)));
  p_call_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret |-> (taken && ret_addr == $past(pc) + TWO));
  p_call_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret |-> cycles == CYC_W'(CYC_CALL));
endmodule

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
  localparam int PERIOD = 10;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] byte0 = '0, byte1 = '0, acc = '0;
  logic [15:0] pc = '0;
  logic cf = 1'b0, zf = 1'b0;
  logic out_valid, taken, push_ret;
  logic [15:0] target, ret_addr;
  logic [3:0] cycles;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rel_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .byte0(byte0), .byte1(byte1),
    .pc(pc), .acc(acc), .cf(cf), .zf(zf), .out_valid(out_valid), .taken(taken),
    .target(target), .push_ret(push_ret), .ret_addr(ret_addr), .cycles(cycles));

  // b0 b1 pc acc cf zf | valid taken target push cycles ret
  localparam logic [80:0] VEC [0:NV-1] = '{
    {8'hE0,8'h01,16'h0002,8'h03,1'b0,1'b0, 1'b1,1'b1,16'h0007,1'b0,4'd7, 16'h0000}, // R5 worked case
    {8'h80,8'h05,16'h0100,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0106,1'b0,4'd5, 16'h0000},
    {8'h8F,8'hFF,16'h0100,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0100,1'b0,4'd5, 16'h0000}, // R3 -1
    {8'h88,8'h00,16'h1000,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0801,1'b0,4'd5, 16'h0000}, // R3 -2048
    {8'h87,8'hFF,16'h0000,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0800,1'b0,4'd5, 16'h0000}, // R3 +2047
    {8'hA0,8'h10,16'h0200,8'h00,1'b0,1'b1, 1'b1,1'b1,16'h0211,1'b0,4'd5, 16'h0000},
    {8'hA0,8'h10,16'h0200,8'h00,1'b1,1'b0, 1'b1,1'b0,16'h0202,1'b0,4'd5, 16'h0000},
    {8'hB0,8'h10,16'h0200,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0211,1'b0,4'd5, 16'h0000},
    {8'hB0,8'h10,16'h0200,8'h00,1'b0,1'b1, 1'b1,1'b0,16'h0202,1'b0,4'd5, 16'h0000},
    {8'hC0,8'h20,16'h0300,8'h00,1'b1,1'b0, 1'b1,1'b1,16'h0321,1'b0,4'd5, 16'h0000},
    {8'hC0,8'h20,16'h0300,8'h00,1'b0,1'b1, 1'b1,1'b0,16'h0302,1'b0,4'd5, 16'h0000},
    {8'hD0,8'h20,16'h0300,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0321,1'b0,4'd5, 16'h0000},
    {8'hD0,8'h20,16'h0300,8'h00,1'b1,1'b0, 1'b1,1'b0,16'h0302,1'b0,4'd5, 16'h0000},
    {8'h90,8'h40,16'h0400,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h0441,1'b1,4'd11,16'h0402},
    {8'hFF,8'hFF,16'h0000,8'h00,1'b0,1'b0, 1'b0,1'b0,16'h0000,1'b0,4'd0, 16'h0000},
    {8'h7F,8'h00,16'h0000,8'h00,1'b0,1'b0, 1'b0,1'b0,16'h0000,1'b0,4'd0, 16'h0000},
    {8'h87,8'hFF,16'hFFFF,8'h00,1'b0,1'b0, 1'b1,1'b1,16'h07FF,1'b0,4'd5, 16'h0000}, // R9
    {8'hEF,8'hFF,16'hFFF0,8'hFF,1'b0,1'b0, 1'b1,1'b1,16'h00EF,1'b0,4'd7, 16'h0000}, // R5 R9
    {8'hE0,8'h00,16'h0010,8'h80,1'b1,1'b1, 1'b1,1'b1,16'h0091,1'b0,4'd7, 16'h0000}, // R5 flags ignored
    {8'h9F,8'hFE,16'hFFFF,8'h00,1'b0,1'b0, 1'b1,1'b1,16'hFFFE,1'b1,4'd11,16'h0001}  // R7 R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 16'(out_valid), 16'h0);
    chk("R1 reset taken", 16'(taken), 16'h0);
    chk("R1 reset push", 16'(push_ret), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {byte0, byte1, pc, acc, cf, zf} = VEC[i][80:39];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 valid", 16'(out_valid), 16'(VEC[i][38]));
      if (VEC[i][38]) begin
        chk("R6 taken", 16'(taken), 16'(VEC[i][37]));
        chk("R4 target", target, VEC[i][36:21]);
        chk("R7 push", 16'(push_ret), 16'(VEC[i][20]));
        chk("R8 cycles", 16'(cycles), 16'(VEC[i][19:16]));
        if (VEC[i][20]) chk("R7 ret", ret_addr, VEC[i][15:0]);
      end else begin
        chk("R1 idle taken", 16'(taken), 16'h0);
      end
    end

    // R2: recognized opcode presented without in_valid
    @(negedge clk);
    {byte0, byte1, pc} = {8'h80, 8'h01, 16'h0000};
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 no valid", 16'(out_valid), 16'h0);
    chk("R1 no valid push", 16'(push_ret), 16'h0);

    // R1: reset in the middle of a call
    byte0 = 8'h90; in_valid = 1'b1;
    @(negedge clk);
    chk("R7 call before reset", 16'(push_ret), 16'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset push", 16'(push_ret), 16'h0);
    chk("R1 mid reset valid", 16'(out_valid), 16'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule